// File: doc/BRIEF.md
# Narrow-to-Word Register Access Bridge

This bridge sits between a host port that issues byte, half-word and word accesses at byte addresses and a peripheral register file that accepts only aligned 32-bit reads and writes. A narrow write becomes a read of the enclosing word, a merge of the addressed lane, and a write of the whole word. A narrow read becomes a word read, with the addressed lane shifted down to bit 0.

The register file can lose the second of two writes to the same word when they arrive close together. To avoid this, the bridge keeps two half-word groups in shadow registers instead of writing them at once. The first group is the block size / block count word. The second is the transfer-mode half of the command word. When the command half-word is written, the bridge writes the block word first and the combined transfer-mode/command word second. Both are full-word writes.

After every downstream write, if the card clock is slow, the bridge holds the host port not-ready for four card-clock periods, rounded up to whole microseconds. A card clock of zero gives a fixed ten-microsecond wait instead.

Top module: `narrow_word_bridge`

## Requirements
- R1: After reset, `host_ready` is 1, `dn_valid` and `host_done` are 0, and both shadows are empty. A half read of the transfer-mode offset is therefore served by a downstream word read.
- R2: A byte write (`host_size`=0) reads the aligned word and writes it back with only the byte lane at shift `host_addr[1:0]*8` replaced.
- R3: A half write (`host_size`=1) to any offset other than 0x04, 0x06, 0x0C or 0x0E reads the aligned word. It then writes the word back with only the 16 bits at shift `host_addr[1:0]*8` replaced.
- R4: A half write to 0x04 or 0x06 causes no downstream write. It merges into the block shadow, and the block shadow becomes pending. The merge base is the downstream word when the block shadow is not pending, and the shadow itself, with no downstream access, when it is pending.
- R5: A half write to 0x0C reads word 0x0C, merges into the command shadow, sets the command shadow pending, and causes no downstream write.
- R6: A half write to 0x0E has two steps. If the block shadow is pending, the bridge first writes it whole to address 0x04. It then writes the command shadow, with its upper half replaced, to address 0x0C. Both shadows are then no longer pending.
- R7: A half write to 0x0E with no pending block shadow produces exactly one downstream write. That write goes to 0x0C, with the lower half taken from the retained command shadow.
- R8: A read returns the addressed lane, zero-extended, on `host_rdata` with `host_done`. A half read of 0x0C while the command shadow is pending, or of 0x04/0x06 while the block shadow is pending, is served from the shadow. Every other read comes from the register file.
- R9: A word write (`host_size`=2) goes downstream unchanged to the aligned address. It does not clear a pending shadow.
- R10: After a downstream write with `card_khz` at or below `SLOW_KHZ`, the bridge waits n microseconds before continuing, where n is the smallest value with n*`card_khz` >= 1000*`PERIODS`. Above `SLOW_KHZ` there is no wait.
- R11: With `card_khz`=0 the wait after each downstream write is `ZERO_US` microseconds.
- R12: `host_done` is a one-cycle pulse per request, given while the port is idle again. The downstream request holds address and data until `dn_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Bridge idle, request accepted when valid |
| host_write | input | 1 | 1 write, 0 read |
| host_size | input | 2 | 0 byte, 1 half-word, 2 word |
| host_addr | input | AW | Byte address |
| host_wdata | input | 32 | Write value, right-aligned |
| host_rdata | output | 32 | Read value, right-aligned, zero-extended |
| host_done | output | 1 | Request completed (one-cycle pulse) |
| card_khz | input | KHZW | Card clock frequency in kHz |
| dn_valid | output | 1 | Downstream access request |
| dn_write | output | 1 | Downstream access is a write |
| dn_addr | output | AW | Aligned downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid with dn_done |
| dn_done | input | 1 | Downstream access finished |

## Verification
The tests use several request patterns, each separating one piece of behaviour:
- **Narrow writes to plain offsets:** byte and half writes at different lanes of a known word show whether the merge shift and mask are right.
- **Block shadow:** two block half-writes separated by a word write to the same word, then read back, show whether the shadow or the register file serves the read. They also show whether the pending flag survives the word write, and whether the second merge skipped the downstream read.
- **Command writes:** command writes with and without a pending block shadow, checked against an ordered scoreboard of downstream writes, show the flush order and that a stale block word is never sent.
- **Pacing:** the same word write and command write repeated at several card frequencies (above, at and below the threshold, and zero) show the rounded wait length by its latency difference.

// File: rtl/nwb_pkg.sv
package nwb_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [1:0] {
    K_PLAIN,
    K_BLK,
    K_XFER,
    K_CMD
  } acc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_FLUSH,
    S_CMD,
    S_WR,
    S_PACE
  } br_state_e;

  localparam int SLOT_BLK = 0;
  localparam int SLOT_CMD = 1;
  localparam int NSLOT    = 2;

  function automatic logic [31:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_HALF: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [4:0] lane_shift(input logic [1:0] lo);
    lane_shift = {lo, 3'b000};
  endfunction

  function automatic logic [31:0] lane_merge(input logic [31:0] base,
                                              input logic [31:0] val,
                                              input logic [1:0]  sz,
                                              input logic [1:0]  lo);
    logic [31:0] m;
    m = lane_mask(sz) << lane_shift(lo);
    lane_merge = (base & ~m) | ((val & lane_mask(sz)) << lane_shift(lo));
  endfunction

  function automatic logic [31:0] lane_pick(input logic [31:0] word,
                                             input logic [1:0]  sz,
                                             input logic [1:0]  lo);
    lane_pick = (word >> lane_shift(lo)) & lane_mask(sz);
  endfunction

endpackage

// File: rtl/nwb_shadow.sv
module nwb_shadow import nwb_pkg::*; #(
  parameter int DW = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NSLOT-1:0]          ld,
  input  logic [NSLOT-1:0]          cl,
  input  logic [DW-1:0]             ld_val,
  output logic [NSLOT-1:0][DW-1:0]  word,
  output logic [NSLOT-1:0]          pend
);

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        word[s] <= '0;
        pend[s] <= 1'b0;
      end else if (ld[s]) begin
        word[s] <= ld_val;
        pend[s] <= 1'b1;
      end else if (cl[s]) begin
        pend[s] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nwb_pace.sv
module nwb_pace #(
  parameter int KHZW     = 16,
  parameter int TICK_DIV = 100,
  parameter int PERIODS  = 4,
  parameter int ZERO_US  = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [KHZW-1:0] khz,
  output logic            done
);

  localparam int LIMIT = PERIODS * 1000;
  localparam int TW    = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int UW    = $clog2(ZERO_US + 1);
  localparam int ACCW  = KHZW + $clog2(LIMIT) + 1;

  logic            active;
  logic [TW-1:0]   tick;
  logic [UW-1:0]   us;
  logic [ACCW-1:0] acc;
  logic [KHZW-1:0] khz_q;
  logic            tick_end;
  logic            finish;

  assign tick_end = (tick == TW'(TICK_DIV - 1));
  assign finish   = (khz_q == '0) ? (us == UW'(ZERO_US - 1))
                                  : ((acc + ACCW'(khz_q)) >= ACCW'(LIMIT));
  assign done     = active && tick_end && finish;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      tick   <= '0;
      us     <= '0;
      acc    <= '0;
      khz_q  <= '0;
    end else if (start) begin
      active <= 1'b1;
      tick   <= '0;
      us     <= '0;
      acc    <= '0;
      khz_q  <= khz;
    end else if (active) begin
      if (tick_end) begin
        tick <= '0;
        us   <= us + 1'b1;
        acc  <= acc + ACCW'(khz_q);
        if (finish) active <= 1'b0;
      end else begin
        tick <= tick + 1'b1;
      end
    end
  end

endmodule

// File: rtl/narrow_word_bridge.sv
module narrow_word_bridge import nwb_pkg::*; #(
  parameter int AW         = 8,
  parameter int KHZW       = 16,
  parameter int TICK_DIV   = 100,
  parameter int SLOW_KHZ   = 400,
  parameter int PERIODS    = 4,
  parameter int ZERO_US    = 10,
  parameter int BLKSZ_OFF  = 4,
  parameter int BLKCNT_OFF = 6,
  parameter int XFER_OFF   = 12,
  parameter int CMD_OFF    = 14
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_valid,
  output logic            host_ready,
  input  logic            host_write,
  input  logic [1:0]      host_size,
  input  logic [AW-1:0]   host_addr,
  input  logic [31:0]     host_wdata,
  output logic [31:0]     host_rdata,
  output logic            host_done,
  input  logic [KHZW-1:0] card_khz,
  output logic            dn_valid,
  output logic            dn_write,
  output logic [AW-1:0]   dn_addr,
  output logic [31:0]     dn_wdata,
  input  logic [31:0]     dn_rdata,
  input  logic            dn_done
);

  localparam logic [AW-1:0] BLK_WORD = AW'(BLKSZ_OFF) & ~AW'(3);
  localparam logic [AW-1:0] CMD_WORD = AW'(CMD_OFF) & ~AW'(3);
  localparam logic [1:0]    CMD_LO   = 2'(CMD_OFF);

  function automatic acc_kind_e classify(input logic [AW-1:0] a, input logic [1:0] sz);
    if (sz != SZ_HALF)                                  classify = K_PLAIN;
    else if (a == AW'(BLKSZ_OFF) || a == AW'(BLKCNT_OFF)) classify = K_BLK;
    else if (a == AW'(XFER_OFF))                        classify = K_XFER;
    else if (a == AW'(CMD_OFF))                         classify = K_CMD;
    else                                                classify = K_PLAIN;
  endfunction

  br_state_e   st, st_n;
  acc_kind_e   kind_q, kind_in;
  logic        req_write;
  logic [1:0]  req_size;
  logic [AW-1:0] req_addr;
  logic [31:0] req_wdata;
  logic        after_cmd, after_cmd_n;
  logic        cap;
  logic        slow;

  logic            dnv_n, dnw_n, done_n;
  logic [AW-1:0]   dna_n;
  logic [31:0]     dnd_n, rdat_n;

  logic [NSLOT-1:0]         sh_ld, sh_cl;
  logic [31:0]              sh_val;
  logic [NSLOT-1:0][31:0]   sh_word;
  logic [NSLOT-1:0]         sh_pend;
  logic                     pace_go, pace_done;
  logic [31:0]              rmw_word;

  nwb_shadow #(.DW(32)) u_shadow (
    .clk(clk), .rst(rst), .ld(sh_ld), .cl(sh_cl), .ld_val(sh_val),
    .word(sh_word), .pend(sh_pend)
  );

  nwb_pace #(.KHZW(KHZW), .TICK_DIV(TICK_DIV), .PERIODS(PERIODS), .ZERO_US(ZERO_US)) u_pace (
    .clk(clk), .rst(rst), .start(pace_go), .khz(card_khz), .done(pace_done)
  );

  assign host_ready = (st == S_IDLE);
  assign slow       = (card_khz <= KHZW'(SLOW_KHZ));
  assign kind_in    = classify(host_addr, host_size);
  assign rmw_word   = lane_merge(dn_rdata, req_wdata, req_size, req_addr[1:0]);

  always_comb begin
    st_n        = st;
    dnv_n       = dn_valid;
    dnw_n       = dn_write;
    dna_n       = dn_addr;
    dnd_n       = dn_wdata;
    rdat_n      = host_rdata;
    done_n      = 1'b0;
    after_cmd_n = after_cmd;
    cap         = 1'b0;
    pace_go     = 1'b0;
    sh_ld       = '0;
    sh_cl       = '0;
    sh_val      = '0;
    unique case (st)
      S_IDLE: begin
        if (host_valid) begin
          cap = 1'b1;
          if (!host_write && kind_in == K_XFER && sh_pend[SLOT_CMD]) begin
            rdat_n = lane_pick(sh_word[SLOT_CMD], SZ_HALF, host_addr[1:0]);
            done_n = 1'b1;
          end else if (!host_write && kind_in == K_BLK && sh_pend[SLOT_BLK]) begin
            rdat_n = lane_pick(sh_word[SLOT_BLK], SZ_HALF, host_addr[1:0]);
            done_n = 1'b1;
          end else if (host_write && host_size == SZ_WORD) begin
            dnv_n = 1'b1; dnw_n = 1'b1;
            dna_n = host_addr & ~AW'(3);
            dnd_n = host_wdata;
            st_n  = S_WR;
          end else if (host_write && kind_in == K_BLK && sh_pend[SLOT_BLK]) begin
            sh_ld[SLOT_BLK] = 1'b1;
            sh_val = lane_merge(sh_word[SLOT_BLK], host_wdata, SZ_HALF, host_addr[1:0]);
            done_n = 1'b1;
          end else if (host_write && kind_in == K_CMD) begin
            if (sh_pend[SLOT_BLK]) begin
              dnv_n = 1'b1; dnw_n = 1'b1;
              dna_n = BLK_WORD;
              dnd_n = sh_word[SLOT_BLK];
              st_n  = S_FLUSH;
            end else begin
              st_n = S_CMD;
            end
          end else begin
            dnv_n = 1'b1; dnw_n = 1'b0;
            dna_n = host_addr & ~AW'(3);
            st_n  = S_RD;
          end
        end
      end
      S_RD: begin
        if (dn_done) begin
          dnv_n = 1'b0;
          if (!req_write) begin
            rdat_n = lane_pick(dn_rdata, req_size, req_addr[1:0]);
            done_n = 1'b1;
            st_n   = S_IDLE;
          end else if (kind_q == K_BLK) begin
            sh_ld[SLOT_BLK] = 1'b1;
            sh_val = rmw_word;
            done_n = 1'b1;
            st_n   = S_IDLE;
          end else if (kind_q == K_XFER) begin
            sh_ld[SLOT_CMD] = 1'b1;
            sh_val = rmw_word;
            done_n = 1'b1;
            st_n   = S_IDLE;
          end else begin
            dnv_n = 1'b1; dnw_n = 1'b1;
            dnd_n = rmw_word;
            st_n  = S_WR;
          end
        end
      end
      S_FLUSH: begin
        if (dn_done) begin
          dnv_n = 1'b0;
          sh_cl[SLOT_BLK] = 1'b1;
          if (slow) begin
            pace_go = 1'b1; after_cmd_n = 1'b1; st_n = S_PACE;
          end else begin
            st_n = S_CMD;
          end
        end
      end
      S_CMD: begin
        dnv_n = 1'b1; dnw_n = 1'b1;
        dna_n = CMD_WORD;
        dnd_n = lane_merge(sh_word[SLOT_CMD], req_wdata, SZ_HALF, CMD_LO);
        sh_cl[SLOT_CMD] = 1'b1;
        st_n  = S_WR;
      end
      S_WR: begin
        if (dn_done) begin
          dnv_n = 1'b0;
          if (slow) begin
            pace_go = 1'b1; after_cmd_n = 1'b0; st_n = S_PACE;
          end else begin
            done_n = 1'b1; st_n = S_IDLE;
          end
        end
      end
      S_PACE: begin
        if (pace_done) begin
          if (after_cmd) st_n = S_CMD;
          else begin
            done_n = 1'b1; st_n = S_IDLE;
          end
        end
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      kind_q     <= K_PLAIN;
      req_write  <= 1'b0;
      req_size   <= 2'd0;
      req_addr   <= '0;
      req_wdata  <= '0;
      after_cmd  <= 1'b0;
      dn_valid   <= 1'b0;
      dn_write   <= 1'b0;
      dn_addr    <= '0;
      dn_wdata   <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
    end else begin
      st         <= st_n;
      after_cmd  <= after_cmd_n;
      dn_valid   <= dnv_n;
      dn_write   <= dnw_n;
      dn_addr    <= dna_n;
      dn_wdata   <= dnd_n;
      host_rdata <= rdat_n;
      host_done  <= done_n;
      if (cap) begin
        kind_q    <= kind_in;
        req_write <= host_write;
        req_size  <= host_size;
        req_addr  <= host_addr;
        req_wdata <= host_wdata;
      end
    end
  end

endmodule

// File: rtl/nwb_checker.sv
module nwb_checker #(
  parameter int AW         = 8,
  parameter int KHZW       = 16,
  parameter int SLOW_KHZ   = 400,
  parameter int BLKSZ_OFF  = 4,
  parameter int BLKCNT_OFF = 6,
  parameter int XFER_OFF   = 12,
  parameter int CMD_OFF    = 14
) (
  input logic            clk,
  input logic            rst,
  input logic            host_valid,
  input logic            host_ready,
  input logic            host_write,
  input logic [1:0]      host_size,
  input logic [AW-1:0]   host_addr,
  input logic            host_done,
  input logic [KHZW-1:0] card_khz,
  input logic            dn_valid,
  input logic            dn_write,
  input logic [AW-1:0]   dn_addr,
  input logic [31:0]     dn_wdata,
  input logic            dn_done
);

  logic half_wr_acc;
  assign half_wr_acc = host_valid && host_ready && host_write && (host_size == 2'd1);

  // R4: block half-writes never start a downstream write
  assert_blk_no_write_R4: assert property (@(posedge clk) disable iff (rst)
    half_wr_acc && (host_addr == AW'(BLKSZ_OFF) || host_addr == AW'(BLKCNT_OFF))
    |=> !(dn_valid && dn_write));

  // R5: transfer-mode half-write never starts a downstream write
  assert_xfer_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    half_wr_acc && (host_addr == AW'(XFER_OFF)) |=> !(dn_valid && dn_write));

  // R6: a command write does not complete in the next cycle
  assert_cmd_goes_down_R6: assert property (@(posedge clk) disable iff (rst)
    half_wr_acc && (host_addr == AW'(CMD_OFF)) |=> !host_done);

  // R10: slow card clock inserts a gap after a downstream write
  assert_slow_gap_R10: assert property (@(posedge clk) disable iff (rst)
    dn_valid && dn_write && dn_done && (card_khz <= KHZW'(SLOW_KHZ))
    |=> !host_done && !dn_valid);

  // R12: completion is a single pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
    host_done |=> !host_done);

  // R12: completion happens with the port idle
  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    host_done |-> host_ready);

  // R12: downstream request held until done
  assert_dn_hold_R12: assert property (@(posedge clk) disable iff (rst)
    dn_valid && !dn_done |=> dn_valid && $stable(dn_addr) && $stable(dn_wdata) && $stable(dn_write));

endmodule

bind narrow_word_bridge nwb_checker #(
  .AW(AW), .KHZW(KHZW), .SLOW_KHZ(SLOW_KHZ), .BLKSZ_OFF(BLKSZ_OFF),
  .BLKCNT_OFF(BLKCNT_OFF), .XFER_OFF(XFER_OFF), .CMD_OFF(CMD_OFF)
) u_chk (
  .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
  .host_write(host_write), .host_size(host_size), .host_addr(host_addr),
  .host_done(host_done), .card_khz(card_khz), .dn_valid(dn_valid),
  .dn_write(dn_write), .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_done(dn_done)
);

// File: tb/narrow_word_bridge_test.sv
module narrow_word_bridge_test;

  localparam int CLK_PERIOD = 10;
  localparam int TDIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [1:0]  host_size = 2'd0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_done;
  logic [15:0] card_khz = 16'd1000;
  logic        dn_valid, dn_write;
  logic [7:0]  dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic        dn_done;

  int n_chk = 0;
  int n_err = 0;
  int n_acc = 0;
  int cycles = 0;
  string cur_tag = "R1";

  logic [31:0] mem [16];

  typedef struct packed { logic [7:0] a; logic [31:0] d; } wr_item_t;
  wr_item_t exp_q[$];

  narrow_word_bridge #(.TICK_DIV(TDIV)) uut (
    .clk(clk), .rst(rst), .host_valid(host_valid), .host_ready(host_ready),
    .host_write(host_write), .host_size(host_size), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_done(host_done),
    .card_khz(card_khz), .dn_valid(dn_valid), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata), .dn_done(dn_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // register file model: one access at a time, done one cycle after request
  always @(posedge clk) begin
    if (rst) begin
      dn_done  <= 1'b0;
      dn_rdata <= '0;
    end else if (dn_valid && !dn_done) begin
      dn_done  <= 1'b1;
      dn_rdata <= mem[dn_addr[5:2]];
      if (dn_write) mem[dn_addr[5:2]] <= dn_wdata;
    end else begin
      dn_done <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for downstream writes
  always @(negedge clk) begin
    if (!rst && dn_valid && dn_done) begin
      n_acc++;
      if (dn_write) begin
        if (exp_q.size() == 0) begin
          chk(0, {cur_tag, " unexpected write"}, dn_wdata, 32'h0);
        end else begin
          wr_item_t e;
          e = exp_q.pop_front();
          chk(dn_addr == e.a, {cur_tag, " write address"}, 32'(dn_addr), 32'(e.a));
          chk(dn_wdata == e.d, {cur_tag, " write data"}, dn_wdata, e.d);
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic push(input logic [7:0] a, input logic [31:0] d);
    exp_q.push_back('{a: a, d: d});
  endtask

  task automatic op(input bit wr, input logic [1:0] sz, input logic [7:0] a,
                    input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    host_valid = 1'b1; host_write = wr; host_size = sz; host_addr = a; host_wdata = wd;
    @(negedge clk);
    host_valid = 1'b0;
    lat = 1;
    while (!host_done && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    if (!host_done) chk(0, {cur_tag, " no completion"}, 0, 1);
    rd = host_rdata;
    chk(exp_q.size() == 0, {cur_tag, " missing write"}, exp_q.size(), 0);
  endtask

  initial begin
    logic [31:0] rd;
    int lat, l0, lc, a0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    mem[3] = 32'h5555_AAAA;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(host_ready == 1'b1, "R1 ready", 32'(host_ready), 1);
    chk(dn_valid == 1'b0, "R1 dn_valid", 32'(dn_valid), 0);
    chk(host_done == 1'b0, "R1 done", 32'(host_done), 0);
    a0 = n_acc;
    op(0, 2'd1, 8'h0C, 0, rd, lat);
    chk(rd == 32'h0000_AAAA, "R1 xfer read from regfile", rd, 32'h0000_AAAA);
    chk(n_acc == a0 + 1, "R1 downstream read count", n_acc - a0, 1);

    // R9 word pass-through, R8 word read
    cur_tag = "R9";
    push(8'h20, 32'hDEAD_BEEF);
    op(1, 2'd2, 8'h20, 32'hDEAD_BEEF, rd, lat);
    cur_tag = "R8";
    op(0, 2'd2, 8'h20, 0, rd, lat);
    chk(rd == 32'hDEAD_BEEF, "R8 word read", rd, 32'hDEAD_BEEF);

    // R2 byte RMW
    cur_tag = "R2";
    push(8'h20, 32'hDEAD_5AEF);
    op(1, 2'd0, 8'h21, 32'h0000_005A, rd, lat);
    cur_tag = "R8";
    op(0, 2'd0, 8'h23, 0, rd, lat);
    chk(rd == 32'h0000_00DE, "R8 byte lane 3", rd, 32'h0000_00DE);

    // R3 half RMW at upper lane
    cur_tag = "R3";
    push(8'h20, 32'h1234_5AEF);
    op(1, 2'd1, 8'h22, 32'h0000_1234, rd, lat);
    chk(mem[8] == 32'h1234_5AEF, "R3 regfile word", mem[8], 32'h1234_5AEF);
    cur_tag = "R8";
    op(0, 2'd1, 8'h22, 0, rd, lat);
    chk(rd == 32'h0000_1234, "R8 half lane 2", rd, 32'h0000_1234);

    // R4 block shadow
    cur_tag = "R4";
    push(8'h04, 32'hAAAA_BBBB);
    op(1, 2'd2, 8'h04, 32'hAAAA_BBBB, rd, lat);
    op(1, 2'd1, 8'h04, 32'h0000_0200, rd, lat);
    chk(mem[1] == 32'hAAAA_BBBB, "R4 regfile untouched", mem[1], 32'hAAAA_BBBB);
    cur_tag = "R9";
    push(8'h04, 32'h7777_6666);
    op(1, 2'd2, 8'h04, 32'h7777_6666, rd, lat);
    op(0, 2'd1, 8'h06, 0, rd, lat);
    chk(rd == 32'h0000_AAAA, "R9 pending kept after word write", rd, 32'h0000_AAAA);
    cur_tag = "R4";
    a0 = n_acc;
    op(1, 2'd1, 8'h06, 32'h0000_0008, rd, lat);
    chk(n_acc == a0, "R4 merge uses shadow, no access", n_acc - a0, 0);
    op(0, 2'd1, 8'h04, 0, rd, lat);
    chk(rd == 32'h0000_0200, "R8 block read from shadow", rd, 32'h0000_0200);

    // R5 transfer-mode shadow
    cur_tag = "R5";
    push(8'h0C, 32'hCCCC_DDDD);
    op(1, 2'd2, 8'h0C, 32'hCCCC_DDDD, rd, lat);
    op(1, 2'd1, 8'h0C, 32'h0000_0021, rd, lat);
    chk(mem[3] == 32'hCCCC_DDDD, "R5 regfile untouched", mem[3], 32'hCCCC_DDDD);
    op(0, 2'd1, 8'h0C, 0, rd, lat);
    chk(rd == 32'h0000_0021, "R5 xfer read from shadow", rd, 32'h0000_0021);

    // R6 command flush order
    cur_tag = "R6";
    push(8'h04, 32'h0008_0200);
    push(8'h0C, 32'h0C3A_0021);
    op(1, 2'd1, 8'h0E, 32'h0000_0C3A, rd, lat);
    push(8'h0C, 32'h1234_5678);
    op(1, 2'd2, 8'h0C, 32'h1234_5678, rd, lat);
    op(0, 2'd1, 8'h0C, 0, rd, lat);
    chk(rd == 32'h0000_5678, "R6 command flag cleared", rd, 32'h0000_5678);
    push(8'h04, 32'h9999_0000);
    op(1, 2'd2, 8'h04, 32'h9999_0000, rd, lat);
    op(0, 2'd1, 8'h04, 0, rd, lat);
    chk(rd == 32'h0000_0000, "R6 block flag cleared", rd, 32'h0000_0000);

    // R7 command with no pending block
    cur_tag = "R7";
    a0 = n_acc;
    push(8'h0C, 32'h0001_0021);
    op(1, 2'd1, 8'h0E, 32'h0000_0001, rd, lat);
    chk(n_acc == a0 + 1, "R7 single access", n_acc - a0, 1);

    // R10 / R11 pacing
    cur_tag = "R10";
    card_khz = 16'd1000;
    push(8'h30, 32'h0000_0001);
    op(1, 2'd2, 8'h30, 32'h0000_0001, rd, l0);
    card_khz = 16'd401;
    push(8'h30, 32'h0000_0002);
    op(1, 2'd2, 8'h30, 32'h0000_0002, rd, lat);
    chk(lat == l0, "R10 401 kHz no wait", lat, l0);
    card_khz = 16'd400;
    push(8'h30, 32'h0000_0003);
    op(1, 2'd2, 8'h30, 32'h0000_0003, rd, lat);
    chk(lat == l0 + 10*TDIV, "R10 400 kHz 10 us", lat, l0 + 10*TDIV);
    card_khz = 16'd300;
    push(8'h30, 32'h0000_0004);
    op(1, 2'd2, 8'h30, 32'h0000_0004, rd, lat);
    chk(lat == l0 + 14*TDIV, "R10 300 kHz rounded 14 us", lat, l0 + 14*TDIV);
    card_khz = 16'd100;
    push(8'h30, 32'h0000_0005);
    op(1, 2'd2, 8'h30, 32'h0000_0005, rd, lat);
    chk(lat == l0 + 40*TDIV, "R10 100 kHz 40 us", lat, l0 + 40*TDIV);
    cur_tag = "R11";
    card_khz = 16'd0;
    push(8'h30, 32'h0000_0006);
    op(1, 2'd2, 8'h30, 32'h0000_0006, rd, lat);
    chk(lat == l0 + 10*TDIV, "R11 zero clock 10 us", lat, l0 + 10*TDIV);

    cur_tag = "R10";
    card_khz = 16'd1000;
    op(1, 2'd1, 8'h04, 32'h0000_0001, rd, lat);
    push(8'h04, 32'h9999_0001);
    push(8'h0C, 32'h0002_0021);
    op(1, 2'd1, 8'h0E, 32'h0000_0002, rd, lc);
    card_khz = 16'd400;
    op(1, 2'd1, 8'h04, 32'h0000_0003, rd, lat);
    push(8'h04, 32'h9999_0003);
    push(8'h0C, 32'h0004_0021);
    op(1, 2'd1, 8'h0E, 32'h0000_0004, rd, lat);
    chk(lat == lc + 20*TDIV, "R10 wait after each of two writes", lat, lc + 20*TDIV);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule